// File: doc/BRIEF.md
# Security-Banked Periodic Tick Timer

This block is a down-counting periodic tick source for a processor with a Secure and a Non-secure security state. A register bus carries a security-state flag with each access, plus an alias flag that lets Secure software address the Non-secure copy of the registers. Counting advances only on cycles where an external clock-enable input is high. The block has one tick-interrupt output per security state, and each output is a one-cycle pulse.

Two builds are chosen by a parameter. The dual build holds two fully independent timers: one serves Secure accesses and the other serves Non-secure accesses. The single build holds one timer. A routing bit hands that timer to one of the two states. The routing bit can only be changed by a direct Secure access. Accesses from the state that does not own the timer see zeros and have no effect. The timer's tick goes out only on the owning state's interrupt output.

Each timer has three registers: a control word, a reload value and the current count. A fourth bus offset holds the routing bit.

Top module: `banked_tick_timer`

## Requirements
- R1: In the dual build (`DUAL`=1), an access with `bus_secure`=1 and `bus_alias`=0 reaches the Secure timer. An access with `bus_secure`=0 reaches the Non-secure timer. Writes to one timer never change the other.
- R2: An access with `bus_secure`=1 and `bus_alias`=1 is treated exactly as a Non-secure access. `bus_alias` has no effect when `bus_secure`=0.
- R3: A tick pulse is one cycle wide. It appears in the cycle after a timer's count steps from 1 to 0, provided that timer's interrupt enable (control bit 1) is set. Each timer's pulse appears only on its own state's output (`irq_tick_s` or `irq_tick_ns`).
- R4: While the run bit (control bit 0) and `cnt_en` are both high, each clock edge does one of two things. A count of 0 loads the reload value (offset 1). Any other count decreases by 1. When `cnt_en` is low, the count holds. With reload value N, ticks come every N+1 enabled cycles.
- R5: The wrap flag (control bit 16) sets when the count steps from 1 to 0. It clears when the control register (offset 0) is read or the current register (offset 2) is written.
- R6: A write of any value to the current register (offset 2) sets the count to 0.
- R7: In the single build, the routing bit is bit 24 at offset 3. When it is 0, the timer belongs to the Secure state and ticks on `irq_tick_s`. When it is 1, the timer belongs to the Non-secure state and ticks on `irq_tick_ns`.
- R8: The routing bit resets to 0.
- R9: The routing bit is written and read only by Secure, non-alias accesses in the single build. In every other case, offset 3 reads zero and ignores writes.
- R10: In the single build, accesses from the state that does not own the timer read zero and ignore writes.
- R11: After reset, all timer registers read zero and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable; the counters step only when this is high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 control, 1 reload, 2 current, 3 routing |
| bus_wdata | input | DATA_W | Write data |
| bus_secure | input | 1 | Security state of the access (1 = Secure) |
| bus_alias | input | 1 | Secure access aimed at the Non-secure registers |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| irq_tick_s | output | 1 | Tick pulse toward the Secure state |
| irq_tick_ns | output | 1 | Tick pulse toward the Non-secure state |

## Verification
The bench drives both builds from one shared bus.

**Access filtering.** It checks that a Non-secure write leaves the Secure timer unchanged, and that an aliased Secure access lands in the Non-secure bank. A decoder that ignored the alias flag would put that write into the Secure reload value instead.

**Routing bit.** It tries to set the routing bit from the Non-secure side and from the dual build. A missing guard would silently move timer ownership. It then moves ownership back and forth in the single build and watches which interrupt output pulses. A wrong routing bit would fire the wrong output.

**Count timing.** It measures the exact cycle of each tick relative to the enabling write. An off-by-one reload would show as a shifted tick.

**Wrap flag.** It checks that the flag survives until a control read and is also cleared by a current-register write. A design that cleared only on read would still report the flag after the write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam int REG_W     = 2;
   localparam int RUN_BIT   = 0;
   localparam int IEN_BIT   = 1;
   localparam int FLAG_BIT  = 16;
   localparam int ROUTE_BIT = 24;

   typedef enum logic [REG_W-1:0] {
      REG_CTRL    = 2'd0,
      REG_RELOAD  = 2'd1,
      REG_CURRENT = 2'd2,
      REG_ROUTE   = 2'd3
   } tick_reg_e;
endpackage

// File: rtl/tick_count_core.sv
module tick_count_core
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              acc_sel,
   input  logic              acc_wr,
   input  tick_reg_e         acc_reg,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              tick_pulse,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              run_o,
   output logic              flag_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             run_q, ien_q, flag_q, pulse_q;
   logic [CNT_W-1:0] reload_q, cnt_q;
   logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl, step, wrap;
   logic             unused_wdata;

   assign wr_ctrl   = acc_sel && acc_wr && (acc_reg == REG_CTRL);
   assign wr_reload = acc_sel && acc_wr && (acc_reg == REG_RELOAD);
   assign wr_cur    = acc_sel && acc_wr && (acc_reg == REG_CURRENT);
   assign rd_ctrl   = acc_sel && !acc_wr && (acc_reg == REG_CTRL);
   assign step      = run_q && cnt_en;
   assign wrap      = step && (cnt_q == ONE);
   assign unused_wdata = ^acc_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ien_q    <= 1'b0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= acc_wdata[RUN_BIT];
            ien_q <= acc_wdata[IEN_BIT];
         end
         if (wr_reload) reload_q <= acc_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (wr_cur)
            cnt_q <= '0;
         else if (step)
            cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - ONE;

         if (wr_cur)
            flag_q <= 1'b0;
         else if (wrap)
            flag_q <= 1'b1;
         else if (rd_ctrl)
            flag_q <= 1'b0;

         pulse_q <= wrap && ien_q && !wr_cur;
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_sel) begin
         unique case (acc_reg)
            REG_CTRL: begin
               acc_rdata[RUN_BIT]  = run_q;
               acc_rdata[IEN_BIT]  = ien_q;
               acc_rdata[FLAG_BIT] = flag_q;
            end
            REG_RELOAD:  acc_rdata = DATA_W'(reload_q);
            REG_CURRENT: acc_rdata = DATA_W'(cnt_q);
            default:     acc_rdata = '0;
         endcase
      end
   end

   assign tick_pulse = pulse_q;
   assign cnt_o      = cnt_q;
   assign run_o      = run_q;
   assign flag_o     = flag_q;
endmodule

// File: rtl/tick_bank_decode.sv
module tick_bank_decode
   import tick_timer_pkg::*;
#(
   parameter int DUAL = 1
) (
   input  logic       bus_sel,
   input  tick_reg_e  reg_sel,
   input  logic       bus_secure,
   input  logic       bus_alias,
   input  logic       route_q,
   output logic [1:0] bank_sel,
   output logic       route_acc,
   output logic       eff_sec
);
   logic reg_acc;

   assign eff_sec   = bus_secure && !bus_alias;
   assign reg_acc   = bus_sel && (reg_sel != REG_ROUTE);
   assign route_acc = bus_sel && (reg_sel == REG_ROUTE);

   generate
      if (DUAL != 0) begin : g_two
         assign bank_sel[0] = reg_acc && eff_sec;
         assign bank_sel[1] = reg_acc && !eff_sec;
      end else begin : g_one
         // owner is Secure when route_q = 0, Non-secure when 1
         assign bank_sel[0] = reg_acc && (eff_sec ^ route_q);
         assign bank_sel[1] = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/banked_tick_timer.sv
module banked_tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32,
   parameter int DUAL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_secure,
   input  logic              bus_alias,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_tick_s,
   output logic              irq_tick_ns
);
   localparam int NUM_BANK = (DUAL != 0) ? 2 : 1;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W)
         $error("banked_tick_timer: CNT_W must lie in 2..DATA_W");
      if (DATA_W <= ROUTE_BIT)
         $error("banked_tick_timer: DATA_W too narrow for the routing bit");
      if (DUAL != 0 && DUAL != 1)
         $error("banked_tick_timer: DUAL must be 0 or 1");
   endgenerate

   tick_reg_e                   reg_sel;
   logic                        route_q, route_acc, eff_sec;
   logic [1:0]                  bank_sel, bank_tick, bank_run, bank_flag;
   logic [1:0]                  bank_wr, bank_curw;
   logic [1:0][DATA_W-1:0]      bank_rdata;
   logic [1:0][CNT_W-1:0]       bank_cnt;
   logic [DATA_W-1:0]           route_rdata;

   assign reg_sel = tick_reg_e'(bus_addr);

   tick_bank_decode #(.DUAL(DUAL)) u_decode (
      .bus_sel    (bus_sel),
      .reg_sel    (reg_sel),
      .bus_secure (bus_secure),
      .bus_alias  (bus_alias),
      .route_q    (route_q),
      .bank_sel   (bank_sel),
      .route_acc  (route_acc),
      .eff_sec    (eff_sec)
   );

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         if (b < NUM_BANK) begin : g_live
            tick_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
               .clk        (clk),
               .rst_n      (rst_n),
               .cnt_en     (cnt_en),
               .acc_sel    (bank_sel[b]),
               .acc_wr     (bus_wr),
               .acc_reg    (reg_sel),
               .acc_wdata  (bus_wdata),
               .acc_rdata  (bank_rdata[b]),
               .tick_pulse (bank_tick[b]),
               .cnt_o      (bank_cnt[b]),
               .run_o      (bank_run[b]),
               .flag_o     (bank_flag[b])
            );
         end else begin : g_tie
            assign bank_rdata[b] = '0;
            assign bank_tick[b]  = 1'b0;
            assign bank_cnt[b]   = '0;
            assign bank_run[b]   = 1'b0;
            assign bank_flag[b]  = 1'b0;
         end
         assign bank_wr[b]   = bank_sel[b] && bus_wr;
         assign bank_curw[b] = bank_wr[b] && (reg_sel == REG_CURRENT);
      end

      if (DUAL == 0) begin : g_route
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               route_q <= 1'b0;
            else if (route_acc && bus_wr && eff_sec)
               route_q <= bus_wdata[ROUTE_BIT];
         end
         always_comb begin
            route_rdata = '0;
            route_rdata[ROUTE_BIT] = route_q && eff_sec;
         end
         assign irq_tick_s  = bank_tick[0] && !route_q;
         assign irq_tick_ns = bank_tick[0] && route_q;
      end else begin : g_noroute
         assign route_q     = 1'b0;
         assign route_rdata = '0;
         assign irq_tick_s  = bank_tick[0];
         assign irq_tick_ns = bank_tick[1];
      end
   endgenerate

   always_comb begin
      if (route_acc)
         bus_rdata = route_rdata;
      else
         bus_rdata = (bank_sel[0] ? bank_rdata[0] : '0) |
                     (bank_sel[1] ? bank_rdata[1] : '0);
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W = 24,
   parameter int DUAL  = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cnt_en,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic [1:0]            bus_addr,
   input logic                  bus_secure,
   input logic                  bus_alias,
   input logic                  irq_tick_s,
   input logic                  irq_tick_ns,
   input logic                  route_q,
   input logic [1:0][CNT_W-1:0] bank_cnt,
   input logic [1:0]            bank_run,
   input logic [1:0]            bank_flag,
   input logic [1:0]            bank_curw
);
   // R3: a tick is a single-cycle pulse
   a_r3_pulse_s_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tick_s |=> !irq_tick_s);
   a_r3_pulse_ns_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tick_ns |=> !irq_tick_ns);

   // R9: routing bit untouched by anything but a direct Secure write
   a_r9_route_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == 2'd3 && !(bus_secure && !bus_alias))
      |=> $stable(route_q));

   generate
      for (genvar i = 0; i < 2; i++) begin : g_chk
         // R6: current-register write zeroes the count
         a_r6_cur_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bank_curw[i] |=> (bank_cnt[i] == '0));
         // R4: a running, enabled, nonzero count decrements
         a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_run[i] && cnt_en && bank_cnt[i] != '0 && !bank_curw[i])
            |=> (bank_cnt[i] == $past(bank_cnt[i]) - CNT_W'(1)));
         // R4: count holds while the enable is low
         a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_en && !bank_curw[i]) |=> $stable(bank_cnt[i]));
         // R5: the 1 -> 0 step sets the wrap flag
         a_r5_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_run[i] && cnt_en && bank_cnt[i] == CNT_W'(1) && !bank_curw[i])
            |=> bank_flag[i]);
      end
   endgenerate
endmodule

bind banked_tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DUAL(DUAL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt_en      (cnt_en),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_secure  (bus_secure),
   .bus_alias   (bus_alias),
   .irq_tick_s  (irq_tick_s),
   .irq_tick_ns (irq_tick_ns),
   .route_q     (route_q),
   .bank_cnt    (bank_cnt),
   .bank_run    (bank_run),
   .bank_flag   (bank_flag),
   .bank_curw   (bank_curw)
);

// File: tb/banked_tick_timer_tb.sv
module banked_tick_timer_tb;
   localparam int CLK_NS = 20;
   localparam int DW     = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_en = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0, bus_alias = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] rd_d, rd_o;
   logic          irq_s_d, irq_ns_d, irq_s_o, irq_ns_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   banked_tick_timer #(.DUAL(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
      .bus_alias(bus_alias), .bus_rdata(rd_d), .irq_tick_s(irq_s_d), .irq_tick_ns(irq_ns_d));

   banked_tick_timer #(.DUAL(0)) u_one (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
      .bus_alias(bus_alias), .bus_rdata(rd_o), .irq_tick_s(irq_s_o), .irq_tick_ns(irq_ns_o));

   typedef struct packed {
      logic          wr;
      logic          sec;
      logic          ali;
      logic [1:0]    addr;
      logic [DW-1:0] wdata;
      logic [DW-1:0] exp_d;
      logic [DW-1:0] exp_o;
   } vec_t;

   localparam int NV = 17;
   // offsets: 0 ctrl, 1 reload, 2 current, 3 routing (bit 24)
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b1, 1'b0, 2'd1, 32'h100,        32'h0,        32'h0},        // R1 S reload
      '{1'b1, 1'b0, 1'b0, 2'd1, 32'h200,        32'h0,        32'h0},        // R1/R10 NS reload
      '{1'b0, 1'b1, 1'b0, 2'd1, 32'h0,          32'h100,      32'h100},      // R1
      '{1'b0, 1'b0, 1'b0, 2'd1, 32'h0,          32'h200,      32'h0},        // R1 R10
      '{1'b0, 1'b1, 1'b1, 2'd1, 32'h0,          32'h200,      32'h0},        // R2 alias read
      '{1'b1, 1'b1, 1'b1, 2'd1, 32'h300,        32'h0,        32'h0},        // R2 alias write
      '{1'b0, 1'b0, 1'b1, 2'd1, 32'h0,          32'h300,      32'h0},        // R2 NS+alias
      '{1'b0, 1'b1, 1'b0, 2'd3, 32'h0,          32'h0,        32'h0},        // R8 route 0
      '{1'b1, 1'b0, 1'b0, 2'd3, 32'h0100_0000,  32'h0,        32'h0},        // R9 NS route write
      '{1'b0, 1'b1, 1'b0, 2'd3, 32'h0,          32'h0,        32'h0},        // R9 ignored
      '{1'b1, 1'b1, 1'b0, 2'd3, 32'h0100_0000,  32'h0,        32'h0},        // R7 route=1
      '{1'b0, 1'b1, 1'b0, 2'd3, 32'h0,          32'h0,        32'h0100_0000},// R9 read back
      '{1'b0, 1'b0, 1'b0, 2'd1, 32'h0,          32'h300,      32'h100},      // R7 NS owns
      '{1'b0, 1'b1, 1'b0, 2'd1, 32'h0,          32'h100,      32'h0},        // R10 S locked out
      '{1'b0, 1'b0, 1'b0, 2'd3, 32'h0,          32'h0,        32'h0},        // R9 NS reads 0
      '{1'b1, 1'b1, 1'b0, 2'd3, 32'h0,          32'h0,        32'h0},        // R7 route=0
      '{1'b0, 1'b1, 1'b0, 2'd1, 32'h0,          32'h100,      32'h100}       // R7 S owns again
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_op(input logic wr, input logic sec, input logic ali, input logic [1:0] addr,
                         input logic [DW-1:0] wdata,
                         output logic [DW-1:0] r_d, output logic [DW-1:0] r_o);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_secure = sec; bus_alias = ali;
      bus_addr = addr; bus_wdata = wdata;
      #2;
      r_d = rd_d; r_o = rd_o;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic sec, input logic ali, input logic [1:0] addr, input logic [DW-1:0] v);
      logic [DW-1:0] a, b;
      bus_op(1'b1, sec, ali, addr, v, a, b);
   endtask

   task automatic run_edges(input int n, output int ps_d, output int pns_d,
                            output int ps_o, output int pns_o, output int first_s_d);
      ps_d = 0; pns_d = 0; ps_o = 0; pns_o = 0; first_s_d = 0;
      cnt_en = 1'b1;
      for (int k = 1; k <= n; k++) begin
         @(posedge clk);
         #1;
         if (irq_s_d)  begin ps_d++; if (first_s_d == 0) first_s_d = k; end
         if (irq_ns_d) pns_d++;
         if (irq_s_o)  ps_o++;
         if (irq_ns_o) pns_o++;
      end
      cnt_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] a, b;
      int ps_d, pns_d, ps_o, pns_o, first;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      check("R11 irq outputs", {28'h0, irq_s_d, irq_ns_d, irq_s_o, irq_ns_o}, 32'h0);
      bus_op(1'b0, 1'b1, 1'b0, 2'd0, '0, a, b);
      check("R11 dual S ctrl", a, 32'h0);
      check("R11 single S ctrl", b, 32'h0);
      bus_op(1'b0, 1'b0, 1'b0, 2'd2, '0, a, b);
      check("R11 dual NS current", a, 32'h0);
      bus_op(1'b0, 1'b1, 1'b0, 2'd3, '0, a, b);
      check("R8 route reset", b, 32'h0);

      // table of accesses, counting disabled
      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i].wr, VEC[i].sec, VEC[i].ali, VEC[i].addr, VEC[i].wdata, a, b);
         if (!VEC[i].wr) begin
            check($sformatf("R1/R2/R7/R9/R10 vec %0d dual", i), a, VEC[i].exp_d);
            check($sformatf("R1/R2/R7/R9/R10 vec %0d single", i), b, VEC[i].exp_o);
         end
      end

      // R4/R3: Secure timer, reload 3, period 4
      wr_reg(1'b1, 1'b0, 2'd1, 32'd3);
      wr_reg(1'b1, 1'b0, 2'd2, 32'h0);
      wr_reg(1'b1, 1'b0, 2'd0, 32'h3);
      run_edges(12, ps_d, pns_d, ps_o, pns_o, first);
      check("R4 first tick cycle", 32'(first), 32'd4);
      check("R4 tick count", 32'(ps_d), 32'd3);
      check("R3 NS output quiet for S timer", 32'(pns_d), 32'd0);

      // R5 flag set, cleared by ctrl read
      bus_op(1'b0, 1'b1, 1'b0, 2'd0, '0, a, b);
      check("R5 flag set", a, 32'h0001_0003);
      bus_op(1'b0, 1'b1, 1'b0, 2'd0, '0, a, b);
      check("R5 flag cleared by read", a, 32'h3);

      // R4 hold, R6 current write, R5 flag cleared by current write
      run_edges(6, ps_d, pns_d, ps_o, pns_o, first);
      bus_op(1'b0, 1'b1, 1'b0, 2'd2, '0, a, b);
      check("R4 count after 6 steps", a, 32'd2);
      @(posedge clk);
      bus_op(1'b0, 1'b1, 1'b0, 2'd2, '0, a, b);
      check("R4 count holds with cnt_en low", a, 32'd2);
      wr_reg(1'b1, 1'b0, 2'd2, 32'h55);
      bus_op(1'b0, 1'b1, 1'b0, 2'd2, '0, a, b);
      check("R6 current write zeroes count", a, 32'd0);
      bus_op(1'b0, 1'b1, 1'b0, 2'd0, '0, a, b);
      check("R5 flag cleared by current write", a, 32'h3);

      // R3/R1 dual NS timer ticks only on NS output
      wr_reg(1'b1, 1'b0, 2'd0, 32'h0);
      wr_reg(1'b0, 1'b0, 2'd1, 32'd1);
      wr_reg(1'b0, 1'b0, 2'd2, 32'h0);
      wr_reg(1'b0, 1'b0, 2'd0, 32'h3);
      run_edges(8, ps_d, pns_d, ps_o, pns_o, first);
      check("R3 dual NS ticks", 32'(pns_d), 32'd4);
      check("R1 dual S stays idle", 32'(ps_d), 32'd0);

      // R7 single build: route to NS
      wr_reg(1'b1, 1'b0, 2'd3, 32'h0100_0000);
      wr_reg(1'b0, 1'b0, 2'd1, 32'd2);
      wr_reg(1'b0, 1'b0, 2'd2, 32'h0);
      wr_reg(1'b0, 1'b0, 2'd0, 32'h3);
      run_edges(9, ps_d, pns_d, ps_o, pns_o, first);
      check("R7 single NS owner ticks", 32'(pns_o), 32'd3);
      check("R7 single S output quiet", 32'(ps_o), 32'd0);

      // R7 route back to Secure: tick now on S output
      wr_reg(1'b1, 1'b0, 2'd3, 32'h0);
      run_edges(3, ps_d, pns_d, ps_o, pns_o, first);
      check("R7 single S owner tick", 32'(ps_o), 32'd1);
      check("R7 single NS output quiet", 32'(pns_o), 32'd0);

      // R8 reset returns routing to Secure
      wr_reg(1'b1, 1'b0, 2'd3, 32'h0100_0000);
      bus_op(1'b0, 1'b1, 1'b0, 2'd3, '0, a, b);
      check("R9 route set", b, 32'h0100_0000);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_op(1'b0, 1'b1, 1'b0, 2'd3, '0, a, b);
      check("R8 route after reset", b, 32'h0);
      bus_op(1'b0, 1'b1, 1'b0, 2'd1, '0, a, b);
      check("R11 reload after reset", a, 32'h0);

      finish_run();
   end
endmodule